// File: doc/BRIEF.md
# Self-Test Scan Bridge

This block sits behind a user instruction of a chip's test access port and turns the user data register into a command and status mailbox for an on-chip self-test controller. A board controller writes a command word in one data scan to start either the logic test or the memory test. It then repeats data scans to poll a completion flag. Once the test is complete, the same scans return the 32-bit signature and a single go/no-go result on the serial output.

The scan side runs on the test clock and uses the capture, shift and update strobes that the port's state machine supplies. The self-test side runs on the functional clock. A start request crosses as a toggle into a three-state controller: `F_IDLE` (no result), `F_RUN` (engine busy) and `F_DONE` (result held). The transitions are as follows:

- launch: from `F_IDLE` or `F_DONE` to `F_RUN`, on a new start toggle.
- finish: from `F_RUN` to `F_DONE`, on the engine's done.
- clear: from any state to `F_IDLE`, while a clear request is pending.

The result registers stay frozen in `F_DONE`. The done flag and an echo of the start toggle are synchronized back to the test clock, and the signature is read only while both show the result is current. The same path serves a power-on test or a periodic in-field test with the device still on the board.

Top module: `selftest_scan_bridge`

## Requirements
- R1: After test reset, a data scan captures an all-zero 40-bit word and `tdo` is low.
- R2: The captured word holds the last updated command in bits [1:0], done in bit 2, pass in bit 3 and the signature in bits [35:4]. Bits [39:36] are zero. Bit 0 is on `tdo` first, and each shift moves the next higher bit out while `tdi` enters bit 39.
- R3: While `user_sel` is low, the strobes are ignored, `tdo` stays low, no start is issued and the latched command is unchanged.
- R4: An update with command 01 gives one start with `bist_mem` low, and command 10 gives one start with `bist_mem` high. Commands 00 and 11 start nothing.
- R5: A start command issued while a test is running produces no further start.
- R6: Done reads 0 while a test runs, including a scan right after the start update, and it reads 1 once the engine has finished.
- R7: When done reads 1, pass and signature equal the engine's reported values, and they stay the same over repeated scans.
- R8: A new start after a completed test makes done, pass and signature read 0 until the new test finishes.
- R9: Asserting `tlr_state` for one test clock, or pulsing `trst_n` low, clears the command and the done status. A stale result does not reappear later, and the next start still works.
- R10: Every `bist_start` pulse lasts exactly one functional clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr_state | input | 1 | Port state machine is in its reset state |
| user_sel | input | 1 | User instruction loaded; selects this register |
| capture_dr | input | 1 | Capture strobe for the data register |
| shift_dr | input | 1 | Shift strobe for the data register |
| update_dr | input | 1 | Update strobe for the data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, low when not selected |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional reset, active low |
| bist_start | output | 1 | One-cycle start pulse to the self-test engine |
| bist_mem | output | 1 | Test kind: 0 logic, 1 memory |
| bist_done | input | 1 | Engine completion pulse |
| bist_pass | input | 1 | Engine go/no-go, valid with done |
| bist_sig | input | 32 | Engine signature, valid with done |

## Verification
A start pulse reaches the engine about three to four functional cycles after the update edge (two synchronizer stages, the edge detect and the output register). The bench therefore counts pulses only after waiting 30 test clocks. Done becomes visible at the test clock one functional cycle after the engine's completion, plus two synchronizer stages. The bench polls only after waiting several hundred test clocks beyond the engine's latency. A scan that follows a start update by one test clock must read done 0, because the toggle echo has not returned. Every scan samples `tdo` on the falling edge, after the capture or shift edge that set it.

// File: rtl/bist_bridge_pkg.sv
package bist_bridge_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_LOGIC = 2'b01,
        CMD_MEM   = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_RUN  = 2'd1,
        F_DONE = 2'd2
    } fstate_e;
endpackage

// File: rtl/bb_sync.sv
module bb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bb_scan.sv
module bb_scan
    import bist_bridge_pkg::*;
#(
    parameter int SIG_W = 32,
    parameter int PAD_W = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tlr,
    input  logic             sel,
    input  logic             cap,
    input  logic             sh,
    input  logic             upd,
    input  logic             tdi,
    output logic             tdo,
    input  logic             done_s,
    input  logic             ack_s,
    input  logic             pass_a,
    input  logic [SIG_W-1:0] sig_a,
    output logic             start_tgl,
    output logic             kind_mem,
    output logic             clr_req
);
    localparam int REG_W = 4 + SIG_W + PAD_W;

    logic [REG_W-1:0] sr_q;
    logic [1:0]       cmd_q;
    logic             done_view;
    logic             is_start;
    logic [REG_W-1:0] status_w;

    // result is current only when the last start has been echoed back
    assign done_view = done_s && (ack_s == start_tgl) && !clr_req;
    assign status_w  = {{PAD_W{1'b0}}, (done_view ? sig_a : {SIG_W{1'b0}}),
                        done_view & pass_a, done_view, cmd_q};
    assign is_start  = (sr_q[1:0] == CMD_LOGIC) || (sr_q[1:0] == CMD_MEM);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q      <= '0;
            cmd_q     <= CMD_NOP;
            start_tgl <= 1'b0;
            kind_mem  <= 1'b0;
            clr_req   <= 1'b1;
        end else if (tlr) begin
            cmd_q   <= CMD_NOP;
            clr_req <= 1'b1;
        end else if (sel) begin
            if (cap) begin
                sr_q <= status_w;
            end else if (sh) begin
                sr_q <= {tdi, sr_q[REG_W-1:1]};
            end else if (upd) begin
                cmd_q <= sr_q[1:0];
                if (is_start) begin
                    start_tgl <= ~start_tgl;
                    kind_mem  <= (sr_q[1:0] == CMD_MEM);
                    clr_req   <= 1'b0;
                end
            end
        end
    end

    assign tdo = sel ? sr_q[0] : 1'b0;

    // R9: the reset state of the port clears the command and arms the clear
    a_r9_tlr_clears: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (cmd_q == CMD_NOP) && clr_req);

    // R3: a deselected register keeps its command
    a_r3_hold_cmd: assert property (@(posedge tck) disable iff (!trst_n)
        (!sel && !tlr) |=> $stable(cmd_q));
endmodule

// File: rtl/bb_func.sv
module bb_func
    import bist_bridge_pkg::*;
#(
    parameter int SIG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgl_a,
    input  logic             kind_a,
    input  logic             clr_a,
    input  logic             eng_done,
    input  logic             eng_pass,
    input  logic [SIG_W-1:0] eng_sig,
    output logic             eng_start,
    output logic             eng_mem,
    output logic             done_o,
    output logic             pass_o,
    output logic [SIG_W-1:0] sig_o,
    output logic             ack_o
);
    fstate_e    state_q, state_d;
    logic       tgl_s, clr_s, tgl_d, evt, launch, finish;

    bb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk(clk), .rst_n(rst_n), .d({clr_a, tgl_a}), .q({clr_s, tgl_s})
    );

    assign evt    = tgl_s ^ tgl_d;
    assign launch = evt && !clr_s && (state_q != F_RUN);
    assign finish = eng_done && !clr_s && (state_q == F_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, finish, clear
    always_comb begin
        state_d = state_q;
        if (clr_s) begin
            state_d = F_IDLE;
        end else begin
            unique case (state_q)
                F_IDLE:  if (evt)      state_d = F_RUN;
                F_RUN:   if (eng_done) state_d = F_DONE;
                F_DONE:  if (evt)      state_d = F_RUN;
                default: state_d = F_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_d     <= 1'b0;
            ack_o     <= 1'b0;
            eng_start <= 1'b0;
            eng_mem   <= 1'b0;
            pass_o    <= 1'b0;
            sig_o     <= '0;
        end else begin
            tgl_d     <= tgl_s;
            ack_o     <= tgl_d;
            eng_start <= launch;
            if (launch) begin
                eng_mem <= kind_a;
                pass_o  <= 1'b0;
                sig_o   <= '0;
            end else if (finish) begin
                pass_o <= eng_pass;
                sig_o  <= eng_sig;
            end
        end
    end

    assign done_o = (state_q == F_DONE);

    // R10: the start pulse is one functional cycle wide
    a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R7: a held result does not move
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_DONE && $past(state_q) == F_DONE) |-> ($stable(sig_o) && $stable(pass_o)));

    // R8: a launched test withdraws the old done
    a_r8_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !done_o);
endmodule

// File: rtl/selftest_scan_bridge.sv
module selftest_scan_bridge #(
    parameter int SIG_W       = 32,
    parameter int PAD_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tlr_state,
    input  logic             user_sel,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    output logic             tdo,
    input  logic             fclk,
    input  logic             frst_n,
    output logic             bist_start,
    output logic             bist_mem,
    input  logic             bist_done,
    input  logic             bist_pass,
    input  logic [SIG_W-1:0] bist_sig
);
    logic             start_tgl, kind_mem, clr_req;
    logic             f_done, f_pass, f_ack;
    logic [SIG_W-1:0] f_sig;
    logic             done_s, ack_s;

    bb_scan #(.SIG_W(SIG_W), .PAD_W(PAD_W)) u_scan (
        .tck(tck), .trst_n(trst_n), .tlr(tlr_state), .sel(user_sel),
        .cap(capture_dr), .sh(shift_dr), .upd(update_dr), .tdi(tdi), .tdo(tdo),
        .done_s(done_s), .ack_s(ack_s), .pass_a(f_pass), .sig_a(f_sig),
        .start_tgl(start_tgl), .kind_mem(kind_mem), .clr_req(clr_req)
    );

    bb_func #(.SIG_W(SIG_W), .SYNC_STAGES(SYNC_STAGES)) u_func (
        .clk(fclk), .rst_n(frst_n), .tgl_a(start_tgl), .kind_a(kind_mem),
        .clr_a(clr_req), .eng_done(bist_done), .eng_pass(bist_pass),
        .eng_sig(bist_sig), .eng_start(bist_start), .eng_mem(bist_mem),
        .done_o(f_done), .pass_o(f_pass), .sig_o(f_sig), .ack_o(f_ack)
    );

    bb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk(tck), .rst_n(trst_n), .d({f_ack, f_done}), .q({ack_s, done_s})
    );
endmodule

// File: tb/tb_selftest_scan_bridge.sv
module tb_selftest_scan_bridge;
    localparam logic [31:0] SIG_L = 32'h1357_9BDF;
    localparam logic [31:0] SIG_M = 32'hDEAD_0042;

    logic tck = 0, fclk = 0;
    logic trst_n = 0, frst_n = 0, tlr_state = 0, user_sel = 1;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo, bist_start, bist_mem, bist_done = 0, bist_pass = 0;
    logic [31:0] bist_sig = '0;

    always #5 tck = ~tck;
    always #7 fclk = ~fclk;

    selftest_scan_bridge dut (
        .tck(tck), .trst_n(trst_n), .tlr_state(tlr_state), .user_sel(user_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .fclk(fclk), .frst_n(frst_n),
        .bist_start(bist_start), .bist_mem(bist_mem), .bist_done(bist_done),
        .bist_pass(bist_pass), .bist_sig(bist_sig)
    );

    // stub self-test engine: logic test 150 cycles, memory test 200 cycles
    int   start_cnt = 0;
    logic last_kind = 0, eng_busy = 0;
    int   eng_cnt = 0;
    always @(posedge fclk) begin
        bist_done <= 1'b0;
        if (bist_start) begin
            start_cnt <= start_cnt + 1;
            last_kind <= bist_mem;
            eng_cnt   <= bist_mem ? 200 : 150;
            eng_busy  <= 1'b1;
        end else if (eng_busy) begin
            if (eng_cnt == 1) begin
                eng_busy  <= 1'b0;
                bist_done <= 1'b1;
                bist_sig  <= last_kind ? SIG_M : SIG_L;
                bist_pass <= !last_kind;
            end
            eng_cnt <= eng_cnt - 1;
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    typedef struct { logic [39:0] val; string tag; } item_t;
    item_t       exp_q[$];
    logic [39:0] got_q[$];

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [39:0] mk(input logic [1:0] cmd, input logic dn,
                                       input logic ps, input logic [31:0] sg);
        return {4'b0000, sg, ps, dn, cmd};
    endfunction

    // monitor: compares each captured word with the next expected item
    initial begin
        forever begin
            wait (got_q.size() != 0);
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard actual %h expected none", got_q.pop_front());
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(it.tag, {24'h0, got_q.pop_front()}, {24'h0, it.val});
            end
        end
    end

    task automatic scan(input bit sel, input logic [39:0] din, output bit quiet);
        logic [39:0] dout;
        @(negedge tck); user_sel = sel; capture_dr = 1;
        @(negedge tck); capture_dr = 0; shift_dr = 1; quiet = 1;
        for (int i = 0; i < 40; i++) begin
            if (i > 0) @(negedge tck);
            dout[i] = tdo;
            if (tdo) quiet = 0;
            tdi = din[i];
        end
        @(negedge tck); shift_dr = 0; update_dr = 1;
        @(negedge tck); update_dr = 0; user_sel = 1;
        if (sel) got_q.push_back(dout);
    endtask

    // driver: push the expected word, then scan
    task automatic xscan(input string tag, input logic [1:0] cmd, input logic [39:0] exp);
        bit q;
        item_t it;
        it.val = exp; it.tag = tag;
        exp_q.push_back(it);
        scan(1'b1, {38'h0, cmd}, q);
    endtask

    task automatic wait_tck(input int n);
        repeat (n) @(negedge tck);
    endtask

    initial begin
        bit q;
        wait_tck(4);
        trst_n = 1; frst_n = 1;
        wait_tck(10);
        chk("R1 tdo low after reset", {63'h0, tdo}, 64'h0);
        xscan("R1 R2 reset word", 2'b00, 40'h0);

        // logic test
        xscan("R6 before start", 2'b01, mk(2'b00, 0, 0, 0));
        xscan("R6 right after start", 2'b00, mk(2'b01, 0, 0, 0));
        xscan("R5 start while running", 2'b10, mk(2'b00, 0, 0, 0));
        wait_tck(30);
        chk("R4 R10 one logic start", start_cnt, 1);
        chk("R4 logic kind", {63'h0, last_kind}, 64'h0);
        wait_tck(300);
        chk("R5 no extra start", start_cnt, 1);
        xscan("R6 R7 logic result", 2'b00, mk(2'b10, 1, 1, SIG_L));
        xscan("R7 result repeat", 2'b00, mk(2'b00, 1, 1, SIG_L));

        // memory test after a finished one
        xscan("R7 before mem start", 2'b10, mk(2'b00, 1, 1, SIG_L));
        xscan("R8 done withdrawn", 2'b00, mk(2'b10, 0, 0, 0));
        wait_tck(30);
        chk("R4 mem start", start_cnt, 2);
        chk("R4 mem kind", {63'h0, last_kind}, 64'h1);
        wait_tck(400);
        xscan("R2 R7 mem result", 2'b11, mk(2'b00, 1, 0, SIG_M));
        wait_tck(50);
        chk("R4 code 11 no start", start_cnt, 2);

        // deselected scans
        scan(1'b0, 40'h1, q);
        chk("R3 tdo quiet deselected", {63'h0, q}, 64'h1);
        wait_tck(50);
        chk("R3 no start deselected", start_cnt, 2);
        xscan("R3 cmd unchanged", 2'b00, mk(2'b11, 1, 0, SIG_M));
        wait_tck(50);
        chk("R4 code 00 no start", start_cnt, 2);

        // clear through the port reset state
        @(negedge tck); tlr_state = 1;
        @(negedge tck); tlr_state = 0;
        xscan("R9 tlr clears", 2'b00, 40'h0);
        wait_tck(100);
        xscan("R9 no stale after tlr", 2'b00, 40'h0);

        // clear through test reset
        xscan("R9 start before trst", 2'b01, 40'h0);
        wait_tck(400);
        xscan("R9 logic done before trst", 2'b00, mk(2'b01, 1, 1, SIG_L));
        @(negedge tck); trst_n = 0;
        @(negedge tck); trst_n = 1;
        xscan("R9 trst clears", 2'b00, 40'h0);
        wait_tck(100);
        xscan("R9 no stale after trst", 2'b10, 40'h0);
        wait_tck(500);
        chk("R9 start after trst", start_cnt, 4);
        xscan("R9 mem after trst", 2'b00, mk(2'b10, 1, 0, SIG_M));

        wait_tck(5);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard actual %0d pending expected 0", exp_q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule